// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This block is the control and status register store of a 32-bit core that runs the six atomic register-access instructions (write, bit-set and bit-clear, each in a register-operand form and an immediate form). The core presents a 12-bit register address, the 3-bit function field of the instruction, the value read from the source register, and the 5-bit source-register field, which doubles as a zero-extended immediate. A valid strobe qualifies the access. The block returns the addressed register's current contents on a combinational read port, so the core can place the old value into the destination register. At the next clock edge it updates the addressed register.

Four machine trap registers are held: the status word, the trap vector base, the exception program counter and the trap cause. All four take fixed reset values, which are parameters and default to zero. Two 64-bit counters are also provided. One counts clock cycles. The other counts retired instructions, signalled by a one-cycle strobe. Each counter can be read and written through its machine-level addresses, and can be read only through a second alias range. A parameter can remove the counters.

Top module: `csr_regfile`

## Requirements
- R1: After reset, the status (0x300), trap vector (0x305), exception PC (0x341) and cause (0x342) registers all read as 0, and both counters read as 0 before the first clock edge that follows reset release.
- R2: `csr_rdata` always shows the addressed register's value from before any update the access makes.
- R3: Function codes 001 (register) and 101 (immediate) replace the addressed register with the operand.
- R4: Function codes 010 (register) and 110 (immediate) OR the operand into the addressed register.
- R5: Function codes 011 (register) and 111 (immediate) clear the operand's set bits in the addressed register.
- R6: Codes with bit 2 set use `rs1_field` zero-extended to 32 bits as the operand. Codes with bit 2 clear use `rs1_value`.
- R7: A set or clear access with `rs1_field` equal to 0 writes nothing, whatever the value on `rs1_value`. An access with `csr_valid` low also writes nothing.
- R8: The cycle counter rises by one on every clock edge that carries no write to it. Its low half reads at 0xB00 and 0xC00, and its high half reads at 0xB80 and 0xC80. A carry out of the low half increments the high half.
- R9: The retired-instruction counter (low half at 0xB02 and 0xC02, high half at 0xB82 and 0xC82) rises by one on each edge where `retire` is high, and otherwise holds its value.
- R10: A write to a counter half takes priority over that counter's increment in the same cycle. The half that is written takes the written value exactly.
- R11: A read of an unimplemented address returns 0, and a write to one changes no register. A write to the read-only alias range (0xC00, 0xC02, 0xC80, 0xC82) is ignored.
- R12: Function codes 000 and 100 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Access qualifier for this cycle |
| csr_addr | input | 12 | Register address |
| csr_op | input | 3 | Instruction function field selecting the access kind |
| rs1_value | input | 32 | Source register value for the register forms |
| rs1_field | input | 5 | Source register index, also the immediate |
| retire | input | 1 | One instruction retires this cycle |
| csr_rdata | output | 32 | Pre-update contents of the addressed register |

## Verification
The embedded properties assume that `csr_addr`, `csr_op`, `rs1_field` and `rs1_value` are held steady from the point where `csr_valid` is sampled until the edge. They also assume that, for the register forms, `rs1_field` names the register whose value appears on `rs1_value`, because a zero field is the only sign of a read without side effects. The stimulus meets both assumptions by changing every input only on the falling clock edge and by sampling the old value before the rising edge. Each trap register is swept through all eight function codes, four immediate patterns and two register-operand patterns. Before every access, the register is seeded through a plain write.

// File: rtl/csr_rf_pkg.sv
package csr_rf_pkg;

   typedef enum logic [2:0] {
      FN_RSV0 = 3'b000,
      FN_WR   = 3'b001,
      FN_SET  = 3'b010,
      FN_CLR  = 3'b011,
      FN_RSV4 = 3'b100,
      FN_WRI  = 3'b101,
      FN_SETI = 3'b110,
      FN_CLRI = 3'b111
   } csr_fn_e;

   localparam logic [11:0] AD_STATUS  = 12'h300;
   localparam logic [11:0] AD_TVEC    = 12'h305;
   localparam logic [11:0] AD_EPC     = 12'h341;
   localparam logic [11:0] AD_CAUSE   = 12'h342;
   localparam logic [11:0] AD_CYC_LO  = 12'hB00;
   localparam logic [11:0] AD_RET_LO  = 12'hB02;
   localparam logic [11:0] AD_CYC_HI  = 12'hB80;
   localparam logic [11:0] AD_RET_HI  = 12'hB82;
   localparam logic [11:0] RO_CYC_LO  = 12'hC00;
   localparam logic [11:0] RO_RET_LO  = 12'hC02;
   localparam logic [11:0] RO_CYC_HI  = 12'hC80;
   localparam logic [11:0] RO_RET_HI  = 12'hC82;

endpackage

// File: rtl/csr_rf_alu.sv
module csr_rf_alu
   import csr_rf_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int FIELD_W = 5
) (
   input  logic [2:0]         fn,
   input  logic [XLEN-1:0]    reg_val,
   input  logic [FIELD_W-1:0] src_field,
   input  logic [XLEN-1:0]    cur_val,
   output logic [XLEN-1:0]    operand,
   output logic [XLEN-1:0]    next_val,
   output logic               wr_req
);

   localparam int PAD_W = XLEN - FIELD_W;

   generate
      if (FIELD_W < 1 || FIELD_W >= XLEN) begin : g_bad_field
         $error("csr_rf_alu: FIELD_W must lie in 1..XLEN-1");
      end
   endgenerate

   csr_fn_e fn_e;
   logic    field_nz;

   assign fn_e     = csr_fn_e'(fn);
   assign field_nz = |src_field;
   assign operand  = fn[2] ? {{PAD_W{1'b0}}, src_field} : reg_val;

   always_comb begin
      next_val = cur_val;
      wr_req   = 1'b0;
      case (fn_e)
         FN_WR, FN_WRI: begin
            next_val = operand;
            wr_req   = 1'b1;
         end
         FN_SET, FN_SETI: begin
            next_val = cur_val | operand;
            wr_req   = field_nz;
         end
         FN_CLR, FN_CLRI: begin
            next_val = cur_val & ~operand;
            wr_req   = field_nz;
         end
         default: begin
            next_val = cur_val;
            wr_req   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/csr_rf_counter.sv
module csr_rf_counter #(
   parameter int XLEN  = 32,
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [XLEN-1:0]  wdata,
   output logic [CNT_W-1:0] count
);

   localparam int HI_W = CNT_W - XLEN;

   generate
      if (CNT_W <= XLEN || CNT_W > 2 * XLEN) begin : g_bad_width
         $error("csr_rf_counter: CNT_W must lie in XLEN+1..2*XLEN");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_lo) begin
         count[XLEN-1:0] <= wdata;
      end else if (wr_hi) begin
         count[CNT_W-1:XLEN] <= wdata[HI_W-1:0];
      end else if (inc) begin
         count <= count + CNT_W'(1);
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_lo && !wr_hi) |=> (count == $past(count) + CNT_W'(1))); // R8
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_lo && !wr_hi) |=> $stable(count)); // R9
   AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (count[XLEN-1:0] == $past(wdata))); // R10

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
   import csr_rf_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          FIELD_W      = 5,
   parameter int          ADDR_W       = 12,
   parameter int          CNT_W        = 64,
   parameter bit          HAS_COUNTERS = 1'b1,
   parameter logic [31:0] STATUS_RST   = 32'h0,
   parameter logic [31:0] TVEC_RST     = 32'h0,
   parameter logic [31:0] EPC_RST      = 32'h0,
   parameter logic [31:0] CAUSE_RST    = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_valid,
   input  logic [ADDR_W-1:0]  csr_addr,
   input  logic [2:0]         csr_op,
   input  logic [XLEN-1:0]    rs1_value,
   input  logic [FIELD_W-1:0] rs1_field,
   input  logic               retire,
   output logic [XLEN-1:0]    csr_rdata
);

   localparam int HI_W = CNT_W - XLEN;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("csr_regfile: XLEN must be 32");
      end
      if (ADDR_W != 12) begin : g_bad_addr
         $error("csr_regfile: ADDR_W must be 12");
      end
   endgenerate

   logic [XLEN-1:0]  status_q, tvec_q, epc_q, cause_q;
   logic [CNT_W-1:0] cyc_cnt, ret_cnt;
   logic [XLEN-1:0]  old_val, operand, next_val;
   logic             addr_hit, wr_req, commit;

   always_comb begin
      old_val  = '0;
      addr_hit = 1'b1;
      case (csr_addr)
         AD_STATUS: old_val = status_q;
         AD_TVEC:   old_val = tvec_q;
         AD_EPC:    old_val = epc_q;
         AD_CAUSE:  old_val = cause_q;
         AD_CYC_LO, RO_CYC_LO: begin
            old_val  = cyc_cnt[XLEN-1:0];
            addr_hit = HAS_COUNTERS;
         end
         AD_CYC_HI, RO_CYC_HI: begin
            old_val[HI_W-1:0] = cyc_cnt[CNT_W-1:XLEN];
            addr_hit          = HAS_COUNTERS;
         end
         AD_RET_LO, RO_RET_LO: begin
            old_val  = ret_cnt[XLEN-1:0];
            addr_hit = HAS_COUNTERS;
         end
         AD_RET_HI, RO_RET_HI: begin
            old_val[HI_W-1:0] = ret_cnt[CNT_W-1:XLEN];
            addr_hit          = HAS_COUNTERS;
         end
         default: addr_hit = 1'b0;
      endcase
   end

   assign csr_rdata = old_val;

   csr_rf_alu #(
      .XLEN    (XLEN),
      .FIELD_W (FIELD_W)
   ) u_alu (
      .fn        (csr_op),
      .reg_val   (rs1_value),
      .src_field (rs1_field),
      .cur_val   (old_val),
      .operand   (operand),
      .next_val  (next_val),
      .wr_req    (wr_req)
   );

   assign commit = csr_valid && wr_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= STATUS_RST;
         tvec_q   <= TVEC_RST;
         epc_q    <= EPC_RST;
         cause_q  <= CAUSE_RST;
      end else if (commit) begin
         if (csr_addr == AD_STATUS) status_q <= next_val;
         if (csr_addr == AD_TVEC)   tvec_q   <= next_val;
         if (csr_addr == AD_EPC)    epc_q    <= next_val;
         if (csr_addr == AD_CAUSE)  cause_q  <= next_val;
      end
   end

   generate
      if (HAS_COUNTERS) begin : g_counters
         csr_rf_counter #(
            .XLEN  (XLEN),
            .CNT_W (CNT_W)
         ) u_cycle (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (1'b1),
            .wr_lo (commit && csr_addr == AD_CYC_LO),
            .wr_hi (commit && csr_addr == AD_CYC_HI),
            .wdata (next_val),
            .count (cyc_cnt)
         );
         csr_rf_counter #(
            .XLEN  (XLEN),
            .CNT_W (CNT_W)
         ) u_instret (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (retire),
            .wr_lo (commit && csr_addr == AD_RET_LO),
            .wr_hi (commit && csr_addr == AD_RET_HI),
            .wdata (next_val),
            .count (ret_cnt)
         );
      end else begin : g_no_counters
         assign cyc_cnt = '0;
         assign ret_cnt = '0;
      end
   endgenerate

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hit |-> (csr_rdata == '0)); // R11
   AST_ZERO_SRC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_op[1] && rs1_field == '0) |=>
      ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R7
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_valid |=>
      ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R7
   AST_RSV_FN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_op[1:0] == 2'b00) |=>
      ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R12
   AST_WRITE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_addr == AD_TVEC && csr_op[1:0] == 2'b01) |=>
      (tvec_q == $past(operand))); // R3
   AST_SET_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_addr == AD_STATUS && csr_op[1:0] == 2'b10 && rs1_field != '0) |=>
      ((status_q & $past(operand)) == $past(operand))); // R4
   AST_CLEAR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_addr == AD_STATUS && csr_op[1:0] == 2'b11 && rs1_field != '0) |=>
      ((status_q & $past(operand)) == '0)); // R5

endmodule

// File: tb/csr_regfile_tb.sv
module csr_regfile_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic        retire = 1'b0;
   logic [11:0] addr = '0;
   logic [2:0]  op = '0;
   logic [31:0] rs1v = '0;
   logic [4:0]  fld = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   csr_regfile u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_valid (valid),
      .csr_addr  (addr),
      .csr_op    (op),
      .rs1_value (rs1v),
      .rs1_field (fld),
      .retire    (retire),
      .csr_rdata (rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // read combinationally without crossing a clock edge
   task automatic peek(input logic [11:0] a, output logic [31:0] v);
      valid = 1'b0;
      addr  = a;
      #1;
      v = rdata;
   endtask

   // one access: drive at falling edge, capture old value, cross rising edge
   task automatic issue(input logic [11:0] a, input logic [2:0] o, input logic [4:0] f,
                        input logic [31:0] d, output logic [31:0] old);
      @(negedge clk);
      addr  = a;
      op    = o;
      fld   = f;
      rs1v  = d;
      valid = 1'b1;
      #1;
      old = rdata;
      @(posedge clk);
      #1;
      valid = 1'b0;
   endtask

   function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] cur,
                                         input logic [4:0] f, input logic [31:0] d);
      logic [31:0] opnd;
      opnd = o[2] ? {27'd0, f} : d;
      case (o[1:0])
         2'b01:   return opnd;
         2'b10:   return (f == 5'd0) ? cur : (cur | opnd);
         2'b11:   return (f == 5'd0) ? cur : (cur & ~opnd);
         default: return cur;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] o, input logic [4:0] f);
      if (o[1:0] == 2'b00)        return "R12";
      if (o[1] && f == 5'd0)      return "R7";
      if (o[2])                   return "R6";
      if (o[1:0] == 2'b01)        return "R3";
      if (o[1:0] == 2'b10)        return "R4";
      return "R5";
   endfunction

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, w, old, seed, a0;
      logic [11:0] regs [4];
      logic [4:0]  flds [4];
      logic [31:0] dats [2];
      regs = '{12'h300, 12'h305, 12'h341, 12'h342};
      flds = '{5'd0, 5'd1, 5'd17, 5'd31};
      dats = '{32'h0F0F_A5C3, 32'hFFFF_0001};

      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values before the first edge after release
      for (int i = 0; i < 4; i++) begin
         peek(regs[i], v);
         check("R1 trap reg", v, 32'h0);
      end
      peek(12'hB00, v); check("R1 cycle", v, 32'h0);
      peek(12'hB02, v); check("R1 instret", v, 32'h0);

      // R2..R7, R12: sweep of trap registers
      for (int r = 0; r < 4; r++) begin
         for (int o = 0; o < 8; o++) begin
            for (int fi = 0; fi < 4; fi++) begin
               for (int di = 0; di < 2; di++) begin
                  seed = 32'h3C3C_5A5A ^ (r * 32'h0101_0001) ^ (o * 32'h0011_0200) ^ (fi * 32'h8000_0013);
                  issue(regs[r], 3'b001, 5'd1, seed, old);
                  issue(regs[r], 3'(o), flds[fi], dats[di], old);
                  check("R2 old value", old, seed);
                  peek(regs[r], v);
                  check(tag_of(3'(o), flds[fi]), v, model(3'(o), seed, flds[fi], dats[di]));
               end
            end
         end
      end

      // R7: valid low writes nothing
      issue(12'h300, 3'b001, 5'd1, 32'h1234_5678, old);
      @(negedge clk);
      addr = 12'h300; op = 3'b001; fld = 5'd1; rs1v = 32'hDEAD_0000; valid = 1'b0;
      @(posedge clk); #1;
      peek(12'h300, v);
      check("R7 valid low", v, 32'h1234_5678);

      // R8: cycle counter steps and aliases
      @(negedge clk);
      peek(12'hB00, a0);
      peek(12'hC00, w);
      check("R8 alias lo", w, a0);
      repeat (7) @(negedge clk);
      peek(12'hC00, v);
      check("R8 seven cycles", v, a0 + 32'd7);

      // R10 and R8: write wins, carry into high half
      issue(12'hB80, 3'b001, 5'd1, 32'd5, old);
      issue(12'hB00, 3'b001, 5'd1, 32'hFFFF_FFFE, old);
      peek(12'hB00, v); check("R10 cycle write wins", v, 32'hFFFF_FFFE);
      peek(12'hB80, v); check("R10 cycle hi kept", v, 32'd5);
      repeat (2) @(posedge clk);
      #1;
      peek(12'hC00, v); check("R8 lo wraps", v, 32'h0);
      peek(12'hC80, v); check("R8 carry to hi", v, 32'd6);

      // R11: read-only alias ignores writes
      issue(12'hC00, 3'b001, 5'd1, 32'h0, old);
      peek(12'hC00, v);
      check("R11 read-only alias", v, old + 32'd1);

      // R9: retire counting
      @(negedge clk);
      peek(12'hB02, a0);
      retire = 1'b1;
      repeat (3) @(negedge clk);
      retire = 1'b0;
      peek(12'hB02, v); check("R9 three retires", v, a0 + 32'd3);
      repeat (4) @(negedge clk);
      peek(12'hC02, v); check("R9 hold without retire", v, a0 + 32'd3);
      peek(12'hC82, v); check("R9 hi half", v, 32'h0);

      // R10: instret write wins over retire
      retire = 1'b1;
      issue(12'hB02, 3'b001, 5'd1, 32'h0000_1234, old);
      retire = 1'b0;
      peek(12'hB02, v); check("R10 instret write wins", v, 32'h0000_1234);

      // R11: unimplemented addresses
      issue(12'h300, 3'b001, 5'd1, 32'hCAFE_0001, old);
      peek(12'h123, v); check("R11 unmapped read", v, 32'h0);
      issue(12'h123, 3'b001, 5'd1, 32'hAAAA_AAAA, old);
      check("R11 unmapped old", old, 32'h0);
      peek(12'h123, v); check("R11 unmapped after write", v, 32'h0);
      issue(12'h301, 3'b001, 5'd1, 32'h5555_5555, old);
      peek(12'h301, v); check("R11 neighbour unmapped", v, 32'h0);
      peek(12'h300, v); check("R11 status untouched", v, 32'hCAFE_0001);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule